// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block sits between the configuration register of an SPI master and its shift engine. It takes the 8-bit prescale setting and a mode bit, works out a divisor, and emits a one-cycle enable pulse from the system clock at every half-period boundary of the serial clock. The shift engine toggles SCLK and samples data on these pulses. The block decodes and clamps the setting and runs the divide counter. It does not pick a divisor for a wanted bit rate, and it does not build the SCLK waveform.

Two encodings are supported:

- **Linear:** an even divisor from a 5-bit field.
- **Exponent-mantissa:** a 4-bit multiplier shifted by a 3-bit power of two. The bits of the power are scattered across the byte.

The half-period length H is half the divisor, rounded down, and never less than one cycle. When H changes, the counter restarts so the new rate takes hold at once. Rewriting the setting with a value that gives the same H leaves the running phase alone.

Top module: `spi_sclk_prescaler`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `sclkTick` is low.
- R2: With `extMode`=0 only bits 4:0 of `prescField` count, and bits 7:5 are ignored. If bit 4 is 1, H = bits 3:0; if bit 4 is 0, H = 2. The result is then clamped to 2..15, so the divisor 2·H always lies in 4..30.
- R3: With `extMode`=1 the divisor is M·2^E. M = bits 3:0 and E = {bit 7, bit 6, bit 4}, with bit 4 as the least significant. H = floor(divisor/2), raised to 1 when M is nonzero. The largest value is a divisor of 1920, giving H = 960.
- R4: With `extMode`=1, bit 5 of `prescField` has no effect on the rate or on the phase of the ticks.
- R5: With `extMode`=1 and M = 0, no tick is produced. A later nonzero setting restarts the ticks under R7.
- R6: While the setting is steady, each tick is one cycle wide and consecutive ticks are exactly H cycles apart.
- R7: When H changes, including through a change of `extMode`, the counter restarts. The first sample after the capturing edge carries no tick, even if the old count had just expired. The first new tick appears in the (H+1)-th cycle after the rising edge that captures the new setting.
- R8: A change of `prescField` or `extMode` that leaves H unchanged does not restart the counter. The next tick still comes H cycles after the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extMode | input | 1 | 0: linear encoding, 1: exponent-mantissa encoding |
| prescField | input | 8 | Prescale setting from the configuration register |
| sclkTick | output | 1 | One-cycle pulse at each SCLK half-period boundary |

## Verification
Two events can fall in the same cycle: the restart caused by a new divisor, and the terminal count of the old divisor. The bench provokes this by running at H = 1, where the counter expires every cycle, and then switching to the linear setting 0x14. The restart cycle must show no tick, and the first tick must arrive in sample 5. A second pairing sets a rewrite of ignored bits right on a tick boundary. It is judged by the next tick arriving exactly H samples later rather than H+1.

// File: rtl/sclk_presc_pkg.sv
package sclk_presc_pkg;

  // Field layout of the prescale setting; positions are decoded behaviour.
  localparam int FIELD_W   = 8;
  localparam int MANT_W    = 4;
  localparam int EXP_W     = 3;
  localparam int LEG_FLAG  = 4;   // linear mode: marks a valid offset value
  localparam int EXP_B0    = 4;   // exponent bit 0
  localparam int EXP_B1    = 6;   // exponent bit 1
  localparam int EXP_B2    = 7;   // exponent bit 2

  localparam int MAX_DIV   = ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1);
  localparam int HALF_W    = $clog2(MAX_DIV / 2 + 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // restart the half-period counter
    logic run;    // a nonzero half-period is active
  } presc_stb_t;

endpackage

// File: rtl/sclk_presc_ctrl.sv
module sclk_presc_ctrl
  import sclk_presc_pkg::*;
#(
  parameter int LEG_MIN_HALF = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extMode,
  input  logic [FIELD_W-1:0] prescField,
  output logic [HALF_W-1:0]  halfLen,
  output presc_stb_t         stb
);

  localparam logic [HALF_W-1:0] LEG_MIN = HALF_W'(LEG_MIN_HALF);

  logic [MANT_W-1:0] mant;
  logic [EXP_W-1:0]  expo;
  logic [HALF_W:0]   extDiv;
  logic [HALF_W-1:0] halfExt;
  logic [HALF_W-1:0] halfLeg;
  logic [HALF_W-1:0] halfNext;
  logic [HALF_W-1:0] halfReg;
  logic              loadReg;
  logic              primed;

  assign mant = prescField[MANT_W-1:0];
  assign expo = {prescField[EXP_B2], prescField[EXP_B1], prescField[EXP_B0]};

  always_comb begin
    extDiv  = {{(HALF_W+1-MANT_W){1'b0}}, mant} << expo;
    halfExt = extDiv[HALF_W:1];
    if (mant != '0 && halfExt == '0) halfExt = HALF_W'(1);

    halfLeg = {{(HALF_W-MANT_W){1'b0}}, prescField[MANT_W-1:0]};
    if (!prescField[LEG_FLAG] || halfLeg < LEG_MIN) halfLeg = LEG_MIN;

    halfNext = extMode ? halfExt : halfLeg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfReg <= '0;
      loadReg <= 1'b0;
      primed  <= 1'b0;
    end else begin
      halfReg <= halfNext;
      loadReg <= (halfNext != halfReg);
      primed  <= 1'b1;
    end
  end

  assign halfLen  = halfReg;
  assign stb.load = loadReg;
  assign stb.run  = (halfReg != '0);

  AST_LEGACY_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !$past(extMode)) |-> (halfReg >= LEG_MIN && halfReg <= HALF_W'(15))) else $error("legacy half out of range"); // R2

  AST_EXT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(extMode) && $past(prescField[MANT_W-1:0]) != '0) |-> (halfReg != '0)) else $error("extended half collapsed to zero"); // R3

endmodule

// File: rtl/sclk_presc_dp.sv
module sclk_presc_dp
  import sclk_presc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  presc_stb_t        stb,
  input  logic [HALF_W-1:0] halfLen,
  output logic              tick
);

  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  logic [HALF_W-1:0] cnt;
  logic              expire;

  assign expire = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  cnt <= '0;
    else if (!stb.run)          cnt <= '0;
    else if (stb.load || expire) cnt <= halfLen - ONE;
    else                        cnt <= cnt - ONE;
  end

  assign tick = stb.run && !stb.load && expire;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.load) |-> (cnt < halfLen)) else $error("count beyond half-period"); // R6

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.load && !expire) |=> (cnt == $past(cnt) - ONE)) else $error("count did not step down"); // R6

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && (stb.load || expire)) |=> (cnt == $past(halfLen) - ONE)) else $error("reload value wrong"); // R7

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler
  import sclk_presc_pkg::*;
#(
  parameter int LEG_MIN_HALF = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extMode,
  input  logic [FIELD_W-1:0] prescField,
  output logic               sclkTick
);

  presc_stb_t        stb;
  logic [HALF_W-1:0] halfLen;

  sclk_presc_ctrl #(.LEG_MIN_HALF(LEG_MIN_HALF)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .extMode    (extMode),
    .prescField (prescField),
    .halfLen    (halfLen),
    .stb        (stb)
  );

  sclk_presc_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .halfLen (halfLen),
    .tick    (sclkTick)
  );

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && prescField[MANT_W-1:0] == '0 && $past(extMode) && $past(prescField[MANT_W-1:0]) == '0)
    |-> !sclkTick) else $error("tick while multiplier is zero"); // R5

endmodule

// File: tb/test_spi_sclk_prescaler.sv
module test_spi_sclk_prescaler;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       extMode = 1'b0;
  logic [7:0] prescField = 8'h14;
  logic       sclkTick;

  int total = 0;
  int fails = 0;

  localparam int LIMIT = 2500;

  always #4 clk = ~clk;   // 125 MHz

  spi_sclk_prescaler i_spi_sclk_prescaler (
    .clk(clk), .rstN(rstN), .extMode(extMode),
    .prescField(prescField), .sclkTick(sclkTick)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Counts negedge samples up to and including the next tick.
  task automatic waitTick(output int n);
    n = 0;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      n++;
      if (sclkTick) break;
    end
  endtask

  task automatic runRate(input logic m, input logic [7:0] f, input int h, input string req);
    int n;
    @(negedge clk);
    extMode = m;
    prescField = f;
    waitTick(n);
    chk(n == h + 1, req, "first tick after restart (R7)", n, h + 1);
    for (int k = 0; k < 3; k++) begin
      waitTick(n);
      chk(n == h, req, "tick spacing (R6)", n, h);
    end
  endtask

  task automatic testReset();
    chk(sclkTick == 1'b0, "R1", "tick during reset", sclkTick, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(sclkTick == 1'b0, "R1", "tick first cycle after reset", sclkTick, 0);
  endtask

  task automatic testCollision();
    int n;
    runRate(1'b1, 8'h01, 1, "R3");
    @(negedge clk);
    extMode = 1'b0;
    prescField = 8'h14;
    @(negedge clk);
    chk(sclkTick == 1'b0, "R7", "tick in restart cycle", sclkTick, 0);
    n = 1;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      n++;
      if (sclkTick) break;
    end
    chk(n == 5, "R7", "first tick after collision", n, 5);
  endtask

  task automatic testIgnored(input logic m, input logic [7:0] f, input logic [7:0] fAlt, input int h, input string req);
    int n;
    runRate(m, f, h, req);
    prescField = fAlt;          // right after a tick, at the sampling negedge
    waitTick(n);
    chk(n == h, req, "phase kept after ignored-bit write (R8)", n, h);
  endtask

  task automatic testStop();
    int cnt;
    @(negedge clk);
    extMode = 1'b1;
    prescField = 8'h40;
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sclkTick) cnt++;
    end
    chk(cnt == 0, "R5", "ticks with zero multiplier", cnt, 0);
    runRate(1'b1, 8'h03, 1, "R5");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    runRate(1'b0, 8'h17, 7, "R2");
    runRate(1'b0, 8'h00, 2, "R2");
    runRate(1'b0, 8'h1F, 15, "R2");
    runRate(1'b0, 8'h11, 2, "R2");
    runRate(1'b0, 8'hF3, 3, "R2");
    testCollision();
    runRate(1'b1, 8'hDF, 960, "R3");
    runRate(1'b1, 8'h13, 3, "R3");
    runRate(1'b1, 8'h05, 2, "R3");
    testIgnored(1'b1, 8'h45, 8'h65, 10, "R4");
    testIgnored(1'b0, 8'h16, 8'hF6, 6, "R8");
    testStop();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R6 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule